// File: doc/BRIEF.md
# Auxiliary Pointer Modify Unit

This block is the address-update stage for a bank of eight 16-bit auxiliary pointers and one coefficient pointer. On each access it takes a pointer select, a modify code and a step-source select. In the same cycle it presents the 23-bit effective address. On the next clock edge it writes the modified pointer back into the bank. Each pointer can be updated in one of three ways:

- Linear: plain 16-bit arithmetic.
- Circular: the pointer is an offset that stays inside a buffer of programmable length, and a buffer start address is added to form the address.
- Bit-reversed: the step is added with the carry running from the most significant bit toward the least significant bit, as FFT index stepping needs. The pointer is never wrapped in this mode.

All state is loaded through one register-write port. This state is the pointers themselves, two step registers, three buffer lengths, five buffer start addresses, the per-pointer circular enables and two 7-bit high parts. Instruction decode and the data memory are outside the block.

Top module: `ptr_modify_unit`

## Requirements
- R1: After reset every pointer, step register, length, start address, enable bit and high part is zero, so every valid access with modify code 0 gives address 0.
- R2: Modify codes are: 0 and 7 no change, 1 post +1, 2 post −1, 3 pre +1, 4 post +n, 5 post −n, 6 post bit-reversed +n. For a linear post modify, the address is {high part, old pointer}. From the next cycle the pointer holds the new value modulo 2^16. Code 0 or 7 leaves all pointers unchanged.
- R3: Pre +1 presents the incremented pointer in the same cycle as its address, and that value is written back.
- R4: For codes 4, 5 and 6, the step select picks n: 0 = step register T0, 1 = step register T1, 2 = current value of pointer 0, 3 = the constant 1.
- R5: When circular mode is active for a pointer, its address low half is (pointer + start address) modulo 2^16. Pointers 0/1, 2/3, 4/5 and 6/7 share start registers 0, 1, 2 and 3, and the coefficient pointer uses start register 4.
- R6: In circular mode an increment whose sum reaches the length L or more wraps to sum − L, so with L = 13 post +1 visits 13 positions.
- R7: In circular mode a decrement by n from a pointer below n wraps to pointer + L − n, so post −1 from 0 gives L − 1.
- R8: Pointers 0–3 take L from length register 0, pointers 4–7 from length register 1, and the coefficient pointer from length register 2.
- R9: Bit-reversed mode adds n with the carry propagating from bit 15 toward bit 0 and never wraps at L. If the pointer's circular enable is on, the start address is still added to the address.
- R10: A length of 0 or 1 makes the pointer fully linear: no wrap and no start address, even with its enable set.
- R11: The coefficient pointer (select 8) uses its own 7-bit high part; pointers 0–7 share the auxiliary high part.
- R12: Circular enables are independent per pointer (mask bit k for pointer k, bit 8 for the coefficient pointer). A pointer whose bit is clear updates linearly.
- R13: Write-port addresses are:
  - 0–8: pointers
  - 9: T0
  - 10: T1
  - 11–13: lengths 0–2
  - 14–18: start addresses 0–4
  - 19: enable mask
  - 20: auxiliary high part
  - 21: coefficient high part

  Writes take effect on the next edge. If a write and a modify hit the same pointer in one cycle, the written value wins.
- R14: A select above 8, or acc_valid low, gives address 0 and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register-write strobe |
| cfg_addr | input | 5 | Register-write address (R13 map) |
| cfg_data | input | 16 | Register-write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_sel | input | 4 | Pointer select: 0–7 auxiliary, 8 coefficient |
| acc_op | input | 3 | Modify code (R2) |
| acc_step_sel | input | 2 | Step source for codes 4–6 (R4) |
| acc_ea | output | 23 | Effective address, combinational from the access inputs |

## Verification
Timing of each result:

- The effective address is combinational, so it is due in the same cycle as the access. The bench drives each access just after a falling edge and compares the address a quarter period later, before the rising edge.
- A pointer update, and any register write, becomes visible one edge later.
- The behavioural model in the bench commits its own state only after that rising edge. The next access therefore reads back the updated pointer, including write-versus-modify collisions and accesses that must change nothing.

// File: rtl/ptrmod_pkg.sv
package ptrmod_pkg;

   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_POST_INC  = 3'd1,
      OP_POST_DEC  = 3'd2,
      OP_PRE_INC   = 3'd3,
      OP_POST_ADDN = 3'd4,
      OP_POST_SUBN = 3'd5,
      OP_POST_BREV = 3'd6,
      OP_NONE_ALT  = 3'd7
   } mod_op_e;

   typedef enum logic [1:0] {
      STEP_T0  = 2'd0,
      STEP_T1  = 2'd1,
      STEP_AR0 = 2'd2,
      STEP_ONE = 2'd3
   } step_src_e;

   typedef enum logic [1:0] {
      DIR_ADD  = 2'd0,
      DIR_SUB  = 2'd1,
      DIR_BREV = 2'd2
   } mod_dir_e;

endpackage

// File: rtl/ptr_cfg_regs.sv
module ptr_cfg_regs #(
   parameter int PW    = 16,
   parameter int HW    = 7,
   parameter int NAUX  = 8,
   parameter int GRP   = 4,
   parameter int PAIR  = 2,
   parameter int CAW   = 5,
   parameter int NPTR  = NAUX + 1,
   parameter int NLEN  = NAUX / GRP + 1,
   parameter int NBASE = NAUX / PAIR + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CAW-1:0]       cfg_addr,
   input  logic [PW-1:0]        cfg_data,
   output logic [PW-1:0]        step_t0,
   output logic [PW-1:0]        step_t1,
   output logic [NLEN-1:0][PW-1:0]  len_arr,
   output logic [NBASE-1:0][PW-1:0] base_arr,
   output logic [NPTR-1:0]      circ_en,
   output logic [HW-1:0]        aux_hi,
   output logic [HW-1:0]        coef_hi
);
   localparam int A_T0    = NPTR;
   localparam int A_T1    = NPTR + 1;
   localparam int A_LEN0  = NPTR + 2;
   localparam int A_BASE0 = A_LEN0 + NLEN;
   localparam int A_MASK  = A_BASE0 + NBASE;
   localparam int A_AHI   = A_MASK + 1;
   localparam int A_CHI   = A_MASK + 2;

   if (A_CHI >= (1 << CAW)) begin : g_bad_caw
      $error("ptr_cfg_regs: CAW too narrow for register map");
   end
   if (PW < NPTR || PW < HW) begin : g_bad_pw
      $error("ptr_cfg_regs: PW must cover the enable mask and high parts");
   end

   function automatic logic hit(input logic [CAW-1:0] a, input int k);
      return a == CAW'(k);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_t0 <= '0;
         step_t1 <= '0;
         circ_en <= '0;
         aux_hi  <= '0;
         coef_hi <= '0;
      end else if (cfg_we) begin
         if (hit(cfg_addr, A_T0))   step_t0 <= cfg_data;
         if (hit(cfg_addr, A_T1))   step_t1 <= cfg_data;
         if (hit(cfg_addr, A_MASK)) circ_en <= cfg_data[NPTR-1:0];
         if (hit(cfg_addr, A_AHI))  aux_hi  <= cfg_data[HW-1:0];
         if (hit(cfg_addr, A_CHI))  coef_hi <= cfg_data[HW-1:0];
      end
   end

   for (genvar g = 0; g < NLEN; g++) begin : g_len
      logic [PW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              r <= '0;
         else if (cfg_we && hit(cfg_addr, A_LEN0 + g)) r <= cfg_data;
      end
      assign len_arr[g] = r;
   end

   for (genvar g = 0; g < NBASE; g++) begin : g_base
      logic [PW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               r <= '0;
         else if (cfg_we && hit(cfg_addr, A_BASE0 + g)) r <= cfg_data;
      end
      assign base_arr[g] = r;
   end

   AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CAW'(A_MASK)) |=> (circ_en == $past(cfg_data[NPTR-1:0]))); // R13

endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
   parameter int PW   = 16,
   parameter int NPTR = 9,
   parameter int CAW  = 5,
   parameter int SELW = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [CAW-1:0]          cfg_addr,
   input  logic [PW-1:0]           cfg_data,
   input  logic                    upd_en,
   input  logic [SELW-1:0]         upd_idx,
   input  logic [PW-1:0]           upd_val,
   output logic [NPTR-1:0][PW-1:0] ptr_q
);
   if ((1 << SELW) < NPTR) begin : g_bad_selw
      $error("ptr_bank: SELW too narrow");
   end

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic [PW-1:0] r;
      logic          cfg_hit;
      logic          upd_hit;
      assign cfg_hit = cfg_we && (cfg_addr == CAW'(g));
      assign upd_hit = upd_en && (upd_idx == SELW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       r <= '0;
         else if (cfg_hit) r <= cfg_data;
         else if (upd_hit) r <= upd_val;
      end
      assign ptr_q[g] = r;

      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_hit && upd_hit) |=> (r == $past(cfg_data))); // R13
   end

endmodule

// File: rtl/ptr_next_calc.sv
module ptr_next_calc
   import ptrmod_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic [PW-1:0] cur,
   input  logic [PW-1:0] step,
   input  logic [PW-1:0] len,
   input  mod_dir_e      dir,
   input  logic          circ_on,
   output logic [PW-1:0] nxt
);
   if (PW < 2) begin : g_bad_pw
      $error("ptr_next_calc: PW must be at least 2");
   end

   logic [PW-1:0] cur_r, step_r, sum_r, brev_sum;

   for (genvar g = 0; g < PW; g++) begin : g_rev
      assign cur_r[g]    = cur[PW-1-g];
      assign step_r[g]   = step[PW-1-g];
      assign brev_sum[g] = sum_r[PW-1-g];
   end
   assign sum_r = cur_r + step_r;

   logic [PW:0]   wide_sum;
   logic [PW-1:0] lin_add, lin_sub, circ_add, circ_sub;

   always_comb begin
      lin_add  = cur + step;
      lin_sub  = cur - step;
      wide_sum = {1'b0, cur} + {1'b0, step};
      if (wide_sum >= {1'b0, len}) circ_add = PW'(wide_sum - {1'b0, len});
      else                         circ_add = wide_sum[PW-1:0];
      if (cur < step) circ_sub = cur + len - step;
      else            circ_sub = lin_sub;
      unique case (dir)
         DIR_SUB:  nxt = circ_on ? circ_sub : lin_sub;
         DIR_BREV: nxt = brev_sum;
         default:  nxt = circ_on ? circ_add : lin_add;
      endcase
   end

endmodule

// File: rtl/ptr_modify_unit.sv
module ptr_modify_unit
   import ptrmod_pkg::*;
#(
   parameter int PW   = 16,
   parameter int AW   = 23,
   parameter int NAUX = 8,
   parameter int GRP  = 4,
   parameter int PAIR = 2,
   parameter int CAW  = 5,
   parameter int SELW = $clog2(NAUX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [CAW-1:0]  cfg_addr,
   input  logic [PW-1:0]   cfg_data,
   input  logic            acc_valid,
   input  logic [SELW-1:0] acc_sel,
   input  logic [2:0]      acc_op,
   input  logic [1:0]      acc_step_sel,
   output logic [AW-1:0]   acc_ea
);
   localparam int HW    = AW - PW;
   localparam int NPTR  = NAUX + 1;
   localparam int NLEN  = NAUX / GRP + 1;
   localparam int NBASE = NAUX / PAIR + 1;
   localparam int CPIX  = NAUX;

   if (HW < 1) begin : g_bad_aw
      $error("ptr_modify_unit: AW must exceed PW");
   end
   if ((NAUX % GRP) != 0 || (NAUX % PAIR) != 0) begin : g_bad_grp
      $error("ptr_modify_unit: NAUX must be a multiple of GRP and PAIR");
   end

   logic [PW-1:0]             step_t0, step_t1;
   logic [NLEN-1:0][PW-1:0]   len_arr;
   logic [NBASE-1:0][PW-1:0]  base_arr;
   logic [NPTR-1:0]           circ_en;
   logic [HW-1:0]             aux_hi, coef_hi;
   logic [NPTR-1:0][PW-1:0]   ptr_q;

   ptr_cfg_regs #(
      .PW(PW), .HW(HW), .NAUX(NAUX), .GRP(GRP), .PAIR(PAIR), .CAW(CAW),
      .NPTR(NPTR), .NLEN(NLEN), .NBASE(NBASE)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .step_t0(step_t0), .step_t1(step_t1),
      .len_arr(len_arr), .base_arr(base_arr), .circ_en(circ_en),
      .aux_hi(aux_hi), .coef_hi(coef_hi)
   );

   // access decode
   logic            sel_ok, is_coef, modifies, is_pre;
   logic [SELW-1:0] idx;
   logic [PW-1:0]   cur, len_sel, base_sel, step, nxt, ea_ptr, ea_low;
   logic [HW-1:0]   hi_sel;
   logic            circ_on;
   mod_op_e         op;
   mod_dir_e        dir;
   int              len_ix, base_ix;

   always_comb begin
      op       = mod_op_e'(acc_op);
      sel_ok   = (int'(acc_sel) <= CPIX);
      idx      = sel_ok ? acc_sel : '0;
      is_coef  = (int'(idx) == CPIX);
      len_ix   = is_coef ? NLEN - 1 : int'(idx) / GRP;
      base_ix  = is_coef ? NBASE - 1 : int'(idx) / PAIR;
      cur      = ptr_q[idx];
      len_sel  = len_arr[len_ix];
      base_sel = base_arr[base_ix];
      hi_sel   = is_coef ? coef_hi : aux_hi;
      circ_on  = circ_en[idx] && (len_sel >= PW'(2));
      is_pre   = (op == OP_PRE_INC);
      modifies = acc_valid && sel_ok && (op != OP_NONE) && (op != OP_NONE_ALT);

      unique case (op)
         OP_POST_ADDN, OP_POST_SUBN, OP_POST_BREV: begin
            unique case (step_src_e'(acc_step_sel))
               STEP_T0:  step = step_t0;
               STEP_T1:  step = step_t1;
               STEP_AR0: step = ptr_q[0];
               default:  step = PW'(1);
            endcase
         end
         default: step = PW'(1);
      endcase

      unique case (op)
         OP_POST_DEC, OP_POST_SUBN: dir = DIR_SUB;
         OP_POST_BREV:              dir = DIR_BREV;
         default:                   dir = DIR_ADD;
      endcase
   end

   ptr_next_calc #(.PW(PW)) calc_i (
      .cur(cur), .step(step), .len(len_sel), .dir(dir),
      .circ_on(circ_on), .nxt(nxt)
   );

   always_comb begin
      ea_ptr = is_pre ? nxt : cur;
      ea_low = circ_on ? ea_ptr + base_sel : ea_ptr;
      acc_ea = (acc_valid && sel_ok) ? {hi_sel, ea_low} : '0;
   end

   ptr_bank #(.PW(PW), .NPTR(NPTR), .CAW(CAW), .SELW(SELW)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .upd_en(modifies), .upd_idx(idx), .upd_val(nxt),
      .ptr_q(ptr_q)
   );

   logic cfg_clash;
   assign cfg_clash = cfg_we && (cfg_addr == CAW'(idx));

   AST_WRITEBACK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (modifies && !cfg_clash) |=> (ptr_q[$past(idx)] == $past(nxt))); // R2

   AST_PRE_SHOWS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (modifies && is_pre && !circ_on && !cfg_clash)
         |=> (ptr_q[$past(idx)] == $past(acc_ea[PW-1:0]))); // R3

   AST_CIRC_STAYS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (modifies && circ_on && dir != DIR_BREV && cur < len_sel && step <= len_sel)
         |-> (nxt < len_sel)); // R6

   AST_LINEAR_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (modifies && !circ_on && op == OP_POST_INC && !cfg_clash)
         |=> (ptr_q[$past(idx)] == $past(cur) + PW'(1))); // R12

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!modifies && !cfg_we) |=> $stable(ptr_q)); // R14

endmodule

// File: tb/ptr_modify_unit_tb_top.sv
module ptr_modify_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic        acc_valid = 1'b0;
   logic [3:0]  acc_sel = '0;
   logic [2:0]  acc_op = '0;
   logic [1:0]  acc_step_sel = '0;
   logic [22:0] acc_ea;

   always #10 clk = ~clk;   // 50 MHz

   ptr_modify_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .acc_valid(acc_valid), .acc_sel(acc_sel),
      .acc_op(acc_op), .acc_step_sel(acc_step_sel), .acc_ea(acc_ea)
   );

   int errs = 0;
   int checks = 0;
   bit done = 0;

   // behavioural reference state
   int ptr [0:8];
   int t0, t1, mask, ahi, chi;
   int lenr [0:2];
   int basr [0:4];

   function automatic int brev_add(input int a, input int b);
      int c = 0;
      int r = 0;
      for (int i = 15; i >= 0; i--) begin
         int s = ((a >> i) & 1) + ((b >> i) & 1) + c;
         r = r | ((s & 1) << i);
         c = s >> 1;
      end
      return r;
   endfunction

   task automatic cyc(input int we, input int ca, input int cd,
                      input int v, input int sel, input int op, input int ss,
                      input string tag);
      int exp_ea = 0;
      int nx = 0;
      int cur, st, ln, bs, hi, ep;
      bit circ, upd;
      @(negedge clk);
      cfg_we = we[0]; cfg_addr = ca[4:0]; cfg_data = cd[15:0];
      acc_valid = v[0]; acc_sel = sel[3:0]; acc_op = op[2:0]; acc_step_sel = ss[1:0];
      #5;
      upd = 0;
      if (v != 0 && sel <= 8) begin
         cur  = ptr[sel];
         ln   = (sel == 8) ? lenr[2] : lenr[sel / 4];
         bs   = (sel == 8) ? basr[4] : basr[sel / 2];
         hi   = (sel == 8) ? chi : ahi;
         circ = ((mask >> sel) & 1) == 1 && ln >= 2;
         st   = 1;
         if (op >= 4 && op <= 6)
            st = (ss == 0) ? t0 : (ss == 1) ? t1 : (ss == 2) ? ptr[0] : 1;
         nx = cur;
         if (op == 1 || op == 3 || op == 4)
            nx = circ ? ((cur + st >= ln) ? cur + st - ln : cur + st) : ((cur + st) & 16'hFFFF);
         else if (op == 2 || op == 5)
            nx = circ ? ((cur < st) ? cur + ln - st : cur - st) : ((cur - st) & 16'hFFFF);
         else if (op == 6)
            nx = brev_add(cur, st);
         upd = (op >= 1 && op <= 6);
         ep = (op == 3) ? nx : cur;
         exp_ea = (hi << 16) | (circ ? ((ep + bs) & 16'hFFFF) : ep);
      end
      if (v != 0) begin
         checks++;
         if (int'(acc_ea) != exp_ea) begin
            errs++;
            $display("FAIL %s sel=%0d op=%0d actual=%06h expected=%06h", tag, sel, op, acc_ea, exp_ea);
         end
      end
      @(posedge clk);
      #1;
      if (upd) ptr[sel] = nx;
      if (we != 0) begin
         if (ca <= 8) ptr[ca] = cd;
         else if (ca == 9)  t0 = cd;
         else if (ca == 10) t1 = cd;
         else if (ca <= 13) lenr[ca - 11] = cd;
         else if (ca <= 18) basr[ca - 14] = cd;
         else if (ca == 19) mask = cd & 9'h1FF;
         else if (ca == 20) ahi = cd & 7'h7F;
         else if (ca == 21) chi = cd & 7'h7F;
      end
   endtask

   task automatic wr(input int a, input int d);
      cyc(1, a, d, 0, 0, 0, 0, "R13");
   endtask

   task automatic acc(input int sel, input int op, input int ss, input string tag);
      cyc(0, 0, 0, 1, sel, op, ss, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL R0 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 9; i++) ptr[i] = 0;
      for (int i = 0; i < 3; i++) lenr[i] = 0;
      for (int i = 0; i < 5; i++) basr[i] = 0;
      t0 = 0; t1 = 0; mask = 0; ahi = 0; chi = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 9; i++) acc(i, 0, 0, "R1");

      // R2: linear post +/-1 with high part; code 7 holds
      wr(20, 3); wr(2, 16'h0100);
      acc(2, 1, 0, "R2"); acc(2, 1, 0, "R2"); acc(2, 2, 0, "R2"); acc(2, 7, 0, "R2");
      acc(2, 0, 0, "R2");
      wr(3, 16'hFFFF); acc(3, 1, 0, "R2"); acc(3, 0, 0, "R2");

      // R3: pre-increment
      wr(5, 16'h0040); acc(5, 3, 0, "R3"); acc(5, 3, 0, "R3"); acc(5, 0, 0, "R3");

      // R4: step sources
      wr(9, 4); wr(10, 16'h0010); wr(0, 2);
      acc(5, 4, 0, "R4"); acc(5, 4, 1, "R4"); acc(5, 4, 2, "R4"); acc(5, 4, 3, "R4");
      acc(5, 5, 1, "R4"); acc(5, 0, 0, "R4");

      // R5/R6/R7: circular on pointer 1, length 13, start 0x2000
      wr(11, 13); wr(14, 16'h2000); wr(19, 16'h0002); wr(1, 0);
      for (int i = 0; i < 15; i++) acc(1, 1, 0, "R6");
      acc(1, 0, 0, "R5");
      wr(1, 0); acc(1, 2, 0, "R7"); acc(1, 0, 0, "R7");
      acc(1, 4, 0, "R6"); acc(1, 4, 0, "R6"); acc(1, 5, 1, "R7");
      acc(1, 5, 0, "R7"); acc(1, 0, 0, "R7");

      // R12: pointer 0 shares length but is not enabled
      wr(0, 12); acc(0, 1, 0, "R12"); acc(0, 1, 0, "R12"); acc(0, 0, 0, "R12");

      // R8: length groups; pointer 4 length 5, coefficient length 3
      wr(12, 5); wr(13, 3); wr(16, 16'h0300); wr(18, 16'h0700);
      wr(19, 16'h0112); wr(4, 3); wr(8, 1);
      for (int i = 0; i < 4; i++) acc(4, 1, 0, "R8");
      for (int i = 0; i < 4; i++) acc(8, 1, 0, "R8");

      // R11: coefficient high part
      wr(21, 16'h0055); acc(8, 0, 0, "R11"); acc(7, 0, 0, "R11");

      // R9: bit-reversed, circular enabled on pointer 6 (length 5)
      wr(17, 16'h4000); wr(19, 16'h0040); wr(6, 0); wr(9, 8);
      for (int i = 0; i < 8; i++) acc(6, 6, 0, "R9");
      wr(9, 16'h0003); wr(6, 16'h8001); acc(6, 6, 0, "R9"); acc(6, 0, 0, "R9");

      // R10: degenerate length is linear
      wr(19, 16'h000A); wr(11, 1); wr(3, 16'h0020);
      acc(3, 1, 0, "R10"); acc(3, 2, 0, "R10"); acc(3, 0, 0, "R10");
      wr(11, 0); acc(3, 2, 0, "R10"); acc(3, 0, 0, "R10");

      // R13: write wins over modify to same pointer
      cyc(1, 2, 16'h0AAA, 1, 2, 1, 0, "R13");
      acc(2, 0, 0, "R13");
      cyc(1, 9, 16'h0077, 1, 5, 0, 0, "R13");
      acc(5, 4, 0, "R13");

      // R14: invalid select and idle cycles change nothing
      acc(9, 1, 0, "R14"); acc(15, 2, 0, "R14");
      cyc(0, 0, 0, 0, 2, 1, 0, "R14");
      acc(2, 0, 0, "R14"); acc(0, 0, 0, "R14");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule